// File: doc/BRIEF.md
# Serial port register front end with one-character receive holding

This block is the software-visible side of a serial port. A CPU reaches it over a simple word-addressed read/write bus, while the line side is reduced to two byte streams: outgoing characters leave on a valid/ready stream and incoming characters (or break events) arrive on another one. Between the two sit the control registers, two status registers, a test/flag register, a set of baud, FIFO-control and millisecond registers that only store what software writes, and one level interrupt.

Reception uses a single holding register rather than a queue. A character that arrives sets the ready flags and closes the receive stream until software reads the data word. That read clears the flags and reopens the stream, so no character is ever overwritten. Transmission uses a single pending slot that stays on the output stream until the consumer takes it. Writing a zero into the reset bit of the second control register performs a soft reset of the port state.

Top module: `sreg_top`

## Requirements
- R1: After reset the registers read as follows: status1 (word 0x25) 0x6040, status2 (0x26) 0x4028, test (0x2D) 0x0060, control1 (0x20) 0x0000, control2 (0x21) 0x0001, control3 (0x22) 0x0700, modulator (0x2A) 0x0000 and baud count (0x2B) 0x0004. The irq output is low and rx_ready is high.
- R2: When rx_valid and rx_ready are both high at a clock edge, the character is stored, status1 bit 9 and status2 bit 0 are set, and test bit 5 is cleared. rx_ready then stays low until the data word is read, and further offered bytes are not taken.
- R3: A read of word 0x00 returns the held value. Bit 15 is set when a character was pending, and the same read clears status1 bit 9 and status2 bit 0, sets test bit 5 and raises rx_ready. Later reads return the same value without bit 15. Before any character arrives, the held value is 0x4000.
- R4: A receive transfer with rx_brk high stores 0x0800 in place of the byte and otherwise behaves exactly as a received character.
- R5: Writing status1 clears only bits 15, 12, 11, 10, 8, 7, 5 and 4 that are written as 1. Writing status2 clears only bits 15, 13, 12, 11, 10, 8, 7, 6, 4, 2 and 1 that are written as 1. Every other status bit, for example status1 bits 14, 13, 9 and 6 or status2 bits 14, 5 and 3, ignores the write.
- R6: irq is a register that goes high one cycle after (status1 bit 9 AND control1 bit 9) OR (status1 bit 13 AND control1 bit 13 AND control1 bit 6) becomes true, and it goes low one cycle after that expression becomes false.
- R7: A write to word 0x10 places its low 8 bits on tx_data with tx_valid high only when control2 bit 2 is 1 and no byte is pending. Otherwise the write is dropped. A pending byte is held stable until tx_ready is seen. While a byte is pending, status1 bit 13, status2 bits 14 and 3, and test bit 6 read as 0.
- R8: Writing control2 with bit 0 equal to 0 restores the R1 values of status, test, control1, control3, modulator, baud count, the receive holding value (0x4000, empty) and the transmit slot (empty). FIFO control and one-ms keep their values. Control2 stores the written value with bit 0 forced to 1. A control2 write with bit 0 equal to 1 stores the value as written.
- R9: Control1, control2, control3, FIFO control (0x24), modulator (0x2A) and one-ms (0x2C) store the low 16 bits of a write. A write to 0x29 updates the value that reads at 0x2B. Words 0x23 and 0x29 read as 0. Writes to 0x23 and 0x2D are ignored. Unknown words read as 0 and ignore writes.
- R10: For every cycle in which bus_sel is high and bus_wr is low, bus_rvalid is high with the read data in the following cycle, and bus_rvalid is low in every other cycle. Each such cycle applies the receive-read side effect once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read strobe |
| tx_valid | output | 1 | Outgoing byte present |
| tx_data | output | CHAR_W | Outgoing byte |
| tx_ready | input | 1 | Consumer takes the outgoing byte |
| rx_valid | input | 1 | Incoming byte or break offered |
| rx_data | input | CHAR_W | Incoming byte |
| rx_brk | input | 1 | Offered item is a break event |
| rx_ready | output | 1 | Holding register is free |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach from the ports is the window where the holding register is full and the source keeps offering bytes. The bench holds rx_valid high with a different byte for several cycles after a capture and checks that rx_ready stays low and that the first byte is still returned. A second hard case is a read strobe held high for two consecutive cycles on the data word, which shows that the valid bit is delivered only once. For soft reset, the bench first loads every storage register, holds a character and enables the receive interrupt. It then writes control2 and checks which registers return to their reset values and which keep what was written.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  localparam int REG_W = 16;

  // word offsets; software decodes these, so they are kept fixed
  localparam logic [7:0] OFF_RXD  = 8'h00;
  localparam logic [7:0] OFF_TXD  = 8'h10;
  localparam logic [7:0] OFF_CTL1 = 8'h20;
  localparam logic [7:0] OFF_CTL2 = 8'h21;
  localparam logic [7:0] OFF_CTL3 = 8'h22;
  localparam logic [7:0] OFF_CTL4 = 8'h23;
  localparam logic [7:0] OFF_FCTL = 8'h24;
  localparam logic [7:0] OFF_STS1 = 8'h25;
  localparam logic [7:0] OFF_STS2 = 8'h26;
  localparam logic [7:0] OFF_BINC = 8'h29;
  localparam logic [7:0] OFF_BMOD = 8'h2A;
  localparam logic [7:0] OFF_BCNT = 8'h2B;
  localparam logic [7:0] OFF_MSEC = 8'h2C;
  localparam logic [7:0] OFF_TEST = 8'h2D;

  // bit positions software relies on
  localparam int RXW_VALID = 15;
  localparam int S1_TXRDY  = 13;
  localparam int S1_RXRDY  = 9;
  localparam int S2_TXMT   = 14;
  localparam int S2_TXDONE = 3;
  localparam int S2_RXRDY  = 0;
  localparam int TST_TXMT  = 6;
  localparam int TST_RXMT  = 5;
  localparam int C1_TXIE   = 13;
  localparam int C1_RXIE   = 9;
  localparam int C1_TXMTIE = 6;
  localparam int C2_TXON   = 2;
  localparam int C2_NRST   = 0;

  // write-one-to-clear masks
  localparam logic [REG_W-1:0] S1_CLR_MASK = 16'h9DB0;
  localparam logic [REG_W-1:0] S2_CLR_MASK = 16'hBDD6;

  // reset values of the stored parts
  localparam logic [REG_W-1:0] STS1_INIT  = 16'h4040;
  localparam logic [REG_W-1:0] STS2_INIT  = 16'h0020;
  localparam logic [REG_W-1:0] CTL1_INIT  = 16'h0000;
  localparam logic [REG_W-1:0] CTL2_INIT  = 16'h0001;
  localparam logic [REG_W-1:0] CTL3_INIT  = 16'h0700;
  localparam logic [REG_W-1:0] BMOD_INIT  = 16'h0000;
  localparam logic [REG_W-1:0] BCNT_INIT  = 16'h0004;
  localparam logic [REG_W-1:0] RXBUF_INIT = 16'h4000;
  localparam logic [REG_W-1:0] BREAK_WORD = 16'h0800;

  typedef struct packed {
    logic rd_rxd;
    logic wr_txd;
    logic wr_ctl1;
    logic wr_ctl2;
    logic wr_ctl3;
    logic wr_fctl;
    logic wr_sts1;
    logic wr_sts2;
    logic wr_binc;
    logic wr_bmod;
    logic wr_msec;
  } sreg_acc_t;

endpackage

// File: rtl/sreg_csr.sv
module sreg_csr
  import sreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  sreg_acc_t        acc,
  input  logic [REG_W-1:0] wdata,
  input  logic             soft_rst,
  output logic [REG_W-1:0] ctl1_q,
  output logic [REG_W-1:0] ctl2_q,
  output logic [REG_W-1:0] ctl3_q,
  output logic [REG_W-1:0] fctl_q,
  output logic [REG_W-1:0] bcnt_q,
  output logic [REG_W-1:0] bmod_q,
  output logic [REG_W-1:0] msec_q,
  output logic [REG_W-1:0] sts1_q,
  output logic [REG_W-1:0] sts2_q
);

  logic [REG_W-1:0] ctl1_d, ctl2_d, ctl3_d, fctl_d, bcnt_d, bmod_d, msec_d;
  logic [REG_W-1:0] sts1_d, sts2_d;
  logic             upd_en;

  assign upd_en = acc.wr_ctl1 | acc.wr_ctl2 | acc.wr_ctl3 | acc.wr_fctl |
                  acc.wr_sts1 | acc.wr_sts2 | acc.wr_binc | acc.wr_bmod |
                  acc.wr_msec | soft_rst;

  always_comb begin
    ctl1_d = ctl1_q;
    ctl2_d = ctl2_q;
    ctl3_d = ctl3_q;
    fctl_d = fctl_q;
    bcnt_d = bcnt_q;
    bmod_d = bmod_q;
    msec_d = msec_q;
    sts1_d = sts1_q;
    sts2_d = sts2_q;
    if (acc.wr_ctl1) ctl1_d = wdata;
    if (acc.wr_ctl3) ctl3_d = wdata;
    if (acc.wr_fctl) fctl_d = wdata;
    if (acc.wr_binc) bcnt_d = wdata;
    if (acc.wr_bmod) bmod_d = wdata;
    if (acc.wr_msec) msec_d = wdata;
    if (acc.wr_sts1) sts1_d = sts1_q & ~(wdata & S1_CLR_MASK);
    if (acc.wr_sts2) sts2_d = sts2_q & ~(wdata & S2_CLR_MASK);
    if (acc.wr_ctl2) begin
      ctl2_d           = wdata;
      ctl2_d[C2_NRST]  = 1'b1;
    end
    if (soft_rst) begin
      ctl1_d = CTL1_INIT;
      ctl3_d = CTL3_INIT;
      bcnt_d = BCNT_INIT;
      bmod_d = BMOD_INIT;
      sts1_d = STS1_INIT;
      sts2_d = STS2_INIT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl1_q <= CTL1_INIT;
      ctl2_q <= CTL2_INIT;
      ctl3_q <= CTL3_INIT;
      fctl_q <= '0;
      bcnt_q <= BCNT_INIT;
      bmod_q <= BMOD_INIT;
      msec_q <= '0;
      sts1_q <= STS1_INIT;
      sts2_q <= STS2_INIT;
    end else if (upd_en) begin
      ctl1_q <= ctl1_d;
      ctl2_q <= ctl2_d;
      ctl3_q <= ctl3_d;
      fctl_q <= fctl_d;
      bcnt_q <= bcnt_d;
      bmod_q <= bmod_d;
      msec_q <= msec_d;
      sts1_q <= sts1_d;
      sts2_q <= sts2_d;
    end
  end

endmodule

// File: rtl/sreg_rxhold.sv
module sreg_rxhold
  import sreg_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              take,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  input  logic              in_brk,
  output logic              in_ready,
  output logic              held_q,
  output logic [REG_W-1:0]  buf_q
);

  logic             held_d;
  logic [REG_W-1:0] buf_d;
  logic             accept;
  logic             upd_en;

  assign in_ready = ~held_q;
  assign accept   = in_valid & ~held_q;
  assign upd_en   = soft_rst | accept | take;

  // soft reset beats a capture, a capture beats a read
  always_comb begin
    held_d = held_q;
    buf_d  = buf_q;
    if (soft_rst) begin
      held_d = 1'b0;
      buf_d  = RXBUF_INIT;
    end else if (accept) begin
      held_d = 1'b1;
      buf_d  = in_brk ? BREAK_WORD : REG_W'(in_data);
    end else if (take) begin
      held_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      buf_q  <= RXBUF_INIT;
    end else if (upd_en) begin
      held_q <= held_d;
      buf_q  <= buf_d;
    end
  end

endmodule

// File: rtl/sreg_txhold.sv
module sreg_txhold #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              load,
  input  logic [CHAR_W-1:0] load_data,
  input  logic              out_ready,
  output logic              pend_q,
  output logic [CHAR_W-1:0] data_q
);

  logic              pend_d;
  logic [CHAR_W-1:0] data_d;
  logic              upd_en;

  assign upd_en = soft_rst | load | (pend_q & out_ready);

  always_comb begin
    pend_d = pend_q;
    data_d = data_q;
    if (soft_rst) begin
      pend_d = 1'b0;
    end else if (pend_q) begin
      if (out_ready) pend_d = 1'b0;
    end else if (load) begin
      pend_d = 1'b1;
      data_d = load_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      data_q <= '0;
    end else if (upd_en) begin
      pend_q <= pend_d;
      data_q <= data_d;
    end
  end

endmodule

// File: rtl/sreg_irq.sv
module sreg_irq
  import sreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] ctl1,
  input  logic             tx_rdy,
  input  logic             rx_rdy,
  output logic             irq_q
);

  logic irq_d;

  always_comb begin
    irq_d = (rx_rdy & ctl1[C1_RXIE]) |
            (tx_rdy & ctl1[C1_TXIE] & ctl1[C1_TXMTIE]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

endmodule

// File: rtl/sreg_top.sv
module sreg_top
  import sreg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              tx_valid,
  output logic [CHAR_W-1:0] tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic              rx_brk,
  output logic              rx_ready,
  output logic              irq
);

  localparam int SYNC_N = 2;

  // reset: asserted asynchronously, released through a short synchroniser
  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_ni = rst_sync_q[SYNC_N-1];

  logic             wr_stb, rd_stb, soft_rst;
  sreg_acc_t        acc;
  logic [REG_W-1:0] wdata_lo;
  logic [REG_W-1:0] ctl1_q, ctl2_q, ctl3_q, fctl_q, bcnt_q, bmod_q, msec_q;
  logic [REG_W-1:0] sts1_q, sts2_q, rxbuf_q;
  logic             rx_held;
  logic [REG_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic             rvalid_q;
  logic             unused_wdata;

  assign wr_stb       = bus_sel & bus_wr;
  assign rd_stb       = bus_sel & ~bus_wr;
  assign wdata_lo     = bus_wdata[REG_W-1:0];
  assign unused_wdata = ^bus_wdata[DATA_W-1:REG_W];

  always_comb begin
    acc         = '0;
    acc.rd_rxd  = rd_stb & (bus_addr == ADDR_W'(OFF_RXD));
    acc.wr_txd  = wr_stb & (bus_addr == ADDR_W'(OFF_TXD));
    acc.wr_ctl1 = wr_stb & (bus_addr == ADDR_W'(OFF_CTL1));
    acc.wr_ctl2 = wr_stb & (bus_addr == ADDR_W'(OFF_CTL2));
    acc.wr_ctl3 = wr_stb & (bus_addr == ADDR_W'(OFF_CTL3));
    acc.wr_fctl = wr_stb & (bus_addr == ADDR_W'(OFF_FCTL));
    acc.wr_sts1 = wr_stb & (bus_addr == ADDR_W'(OFF_STS1));
    acc.wr_sts2 = wr_stb & (bus_addr == ADDR_W'(OFF_STS2));
    acc.wr_binc = wr_stb & (bus_addr == ADDR_W'(OFF_BINC));
    acc.wr_bmod = wr_stb & (bus_addr == ADDR_W'(OFF_BMOD));
    acc.wr_msec = wr_stb & (bus_addr == ADDR_W'(OFF_MSEC));
  end

  assign soft_rst = acc.wr_ctl2 & ~wdata_lo[C2_NRST];

  sreg_csr csr_i (
    .clk      (clk),
    .rst_n    (rst_ni),
    .acc      (acc),
    .wdata    (wdata_lo),
    .soft_rst (soft_rst),
    .ctl1_q   (ctl1_q),
    .ctl2_q   (ctl2_q),
    .ctl3_q   (ctl3_q),
    .fctl_q   (fctl_q),
    .bcnt_q   (bcnt_q),
    .bmod_q   (bmod_q),
    .msec_q   (msec_q),
    .sts1_q   (sts1_q),
    .sts2_q   (sts2_q)
  );

  sreg_rxhold #(.CHAR_W(CHAR_W)) rxh_i (
    .clk      (clk),
    .rst_n    (rst_ni),
    .soft_rst (soft_rst),
    .take     (acc.rd_rxd),
    .in_valid (rx_valid),
    .in_data  (rx_data),
    .in_brk   (rx_brk),
    .in_ready (rx_ready),
    .held_q   (rx_held),
    .buf_q    (rxbuf_q)
  );

  sreg_txhold #(.CHAR_W(CHAR_W)) txh_i (
    .clk       (clk),
    .rst_n     (rst_ni),
    .soft_rst  (soft_rst),
    .load      (acc.wr_txd & ctl2_q[C2_TXON]),
    .load_data (bus_wdata[CHAR_W-1:0]),
    .out_ready (tx_ready),
    .pend_q    (tx_valid),
    .data_q    (tx_data)
  );

  sreg_irq irq_i (
    .clk    (clk),
    .rst_n  (rst_ni),
    .ctl1   (ctl1_q),
    .tx_rdy (~tx_valid),
    .rx_rdy (rx_held),
    .irq_q  (irq)
  );

  // read view: stored bits overlaid with the live flags
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(OFF_RXD):  begin
        rd_mux            = rxbuf_q;
        rd_mux[RXW_VALID] = rxbuf_q[RXW_VALID] | rx_held;
      end
      ADDR_W'(OFF_CTL1): rd_mux = ctl1_q;
      ADDR_W'(OFF_CTL2): rd_mux = ctl2_q;
      ADDR_W'(OFF_CTL3): rd_mux = ctl3_q;
      ADDR_W'(OFF_FCTL): rd_mux = fctl_q;
      ADDR_W'(OFF_STS1): begin
        rd_mux           = sts1_q;
        rd_mux[S1_TXRDY] = ~tx_valid;
        rd_mux[S1_RXRDY] = rx_held;
      end
      ADDR_W'(OFF_STS2): begin
        rd_mux            = sts2_q;
        rd_mux[S2_TXMT]   = ~tx_valid;
        rd_mux[S2_TXDONE] = ~tx_valid;
        rd_mux[S2_RXRDY]  = rx_held;
      end
      ADDR_W'(OFF_BMOD): rd_mux = bmod_q;
      ADDR_W'(OFF_BCNT): rd_mux = bcnt_q;
      ADDR_W'(OFF_MSEC): rd_mux = msec_q;
      ADDR_W'(OFF_TEST): begin
        rd_mux[TST_TXMT] = ~tx_valid;
        rd_mux[TST_RXMT] = ~rx_held;
      end
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_stb;
      if (rd_stb) rdata_q <= DATA_W'(rd_mux);
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

endmodule

// File: rtl/sreg_chk.sv
module sreg_chk
  import sreg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wbit0,
  input logic              bus_rvalid,
  input logic              tx_valid,
  input logic [CHAR_W-1:0] tx_data,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              irq,
  input logic [REG_W-1:0]  ctl1,
  input logic              txen
);

  logic srst, rd_any, rd_rxd, wr_txd;
  assign srst   = bus_sel & bus_wr & (bus_addr == ADDR_W'(OFF_CTL2)) & ~wbit0;
  assign rd_any = bus_sel & ~bus_wr;
  assign rd_rxd = rd_any & (bus_addr == ADDR_W'(OFF_RXD));
  assign wr_txd = bus_sel & bus_wr & (bus_addr == ADDR_W'(OFF_TXD));

  AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_any |=> bus_rvalid); // R10
  AST_RVALID_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_any |=> !bus_rvalid); // R10
  AST_RX_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !srst) |=> !rx_ready); // R2
  AST_RX_READ_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rxd && !rx_ready) |=> rx_ready); // R3
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !srst) |=> (tx_valid && $stable(tx_data))); // R7
  AST_TX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_txd && !txen && !tx_valid) |=> !tx_valid); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl1[C1_RXIE] && !ctl1[C1_TXMTIE]) |=> !irq); // R6
  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (rx_ready && !tx_valid)); // R8

endmodule

bind sreg_top sreg_chk #(.ADDR_W(ADDR_W), .CHAR_W(CHAR_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_ni),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .wbit0      (bus_wdata[0]),
  .bus_rvalid (bus_rvalid),
  .tx_valid   (tx_valid),
  .tx_data    (tx_data),
  .tx_ready   (tx_ready),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .irq        (irq),
  .ctl1       (ctl1_q),
  .txen       (ctl2_q[2])
);

// File: tb/sreg_top_tb_top.sv
`timescale 1ns/1ps
module sreg_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        tx_valid, tx_ready;
  logic [7:0]  tx_data;
  logic        rx_valid, rx_brk, rx_ready;
  logic [7:0]  rx_data;
  logic        irq;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  sreg_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_brk(rx_brk),
    .rx_ready(rx_ready), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic push(input logic [7:0] d, input logic brk);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_brk = brk;
    @(negedge clk);
    rx_valid = 1'b0; rx_brk = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 rx_ready", 32'(rx_ready), 32'h1);
    chk("R1 irq", 32'(irq), 32'h0);
    rd_chk("R1 sts1", 8'h25, 32'h6040);
    rd_chk("R1 sts2", 8'h26, 32'h4028);
    rd_chk("R1 test", 8'h2D, 32'h0060);
    rd_chk("R1 ctl1", 8'h20, 32'h0000);
    rd_chk("R1 ctl2", 8'h21, 32'h0001);
    rd_chk("R1 ctl3", 8'h22, 32'h0700);
    rd_chk("R1 bmod", 8'h2A, 32'h0000);
    rd_chk("R1 bcnt", 8'h2B, 32'h0004);
    rd_chk("R3 empty rxd", 8'h00, 32'h4000);
  endtask

  task automatic t_rx;
    push(8'h5A, 1'b0);
    chk("R2 ready low", 32'(rx_ready), 32'h0);
    rd_chk("R2 sts1", 8'h25, 32'h6240);
    rd_chk("R2 sts2", 8'h26, 32'h4029);
    rd_chk("R2 test", 8'h2D, 32'h0040);
    rd_chk("R3 rxd valid", 8'h00, 32'h805A);
    chk("R3 ready back", 32'(rx_ready), 32'h1);
    rd_chk("R3 sts1 after", 8'h25, 32'h6040);
    rd_chk("R3 sts2 after", 8'h26, 32'h4028);
    rd_chk("R3 test after", 8'h2D, 32'h0060);
    rd_chk("R3 reread", 8'h00, 32'h005A);
  endtask

  task automatic t_backpressure;
    push(8'h31, 1'b0);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'h77;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2 held off", 32'(rx_ready), 32'h0);
    end
    rx_valid = 1'b0;
    rd_chk("R2 first kept", 8'h00, 32'h8031);
  endtask

  task automatic t_break;
    push(8'hC3, 1'b1);
    rd_chk("R4 brk sts1", 8'h25, 32'h6240);
    rd_chk("R4 brk word", 8'h00, 32'h8800);
  endtask

  task automatic t_w1c;
    wr(8'h25, 32'h0000FFFF);
    rd_chk("R5 sts1 keep", 8'h25, 32'h6040);
    wr(8'h26, 32'h0000FFFF);
    rd_chk("R5 sts2 keep", 8'h26, 32'h4028);
    push(8'h10, 1'b0);
    wr(8'h25, 32'h0000FFFF);
    wr(8'h26, 32'h0000FFFF);
    rd_chk("R5 rrdy kept", 8'h25, 32'h6240);
    rd_chk("R5 rdr kept", 8'h26, 32'h4029);
    rd_chk("R5 char kept", 8'h00, 32'h8010);
  endtask

  task automatic t_timing;
    logic [31:0] v;
    push(8'hA5, 1'b0);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h00;
    @(negedge clk);
    chk("R10 rvalid", 32'(bus_rvalid), 32'h1);
    chk("R10 first", bus_rdata, 32'h80A5);
    @(negedge clk);
    chk("R10 second", bus_rdata, 32'h00A5);
    bus_sel = 1'b0;
    @(negedge clk);
    chk("R10 rvalid low", 32'(bus_rvalid), 32'h0);
    rd(8'h00, v);
    chk("R10 once", v, 32'h00A5);
  endtask

  task automatic t_tx;
    wr(8'h10, 32'h000001A5);
    chk("R7 dropped", 32'(tx_valid), 32'h0);
    wr(8'h21, 32'h00000005);
    rd_chk("R8 ctl2 as written", 8'h21, 32'h0005);
    wr(8'h10, 32'h000003C7);
    chk("R7 valid", 32'(tx_valid), 32'h1);
    chk("R7 data", 32'(tx_data), 32'h00C7);
    rd_chk("R7 sts1 busy", 8'h25, 32'h4040);
    rd_chk("R7 sts2 busy", 8'h26, 32'h0020);
    rd_chk("R7 test busy", 8'h2D, 32'h0020);
    wr(8'h10, 32'h00000011);
    chk("R7 hold data", 32'(tx_data), 32'h00C7);
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    chk("R7 taken", 32'(tx_valid), 32'h0);
    rd_chk("R7 sts1 idle", 8'h25, 32'h6040);
  endtask

  task automatic t_irq;
    wr(8'h20, 32'h00002000);
    repeat (2) @(negedge clk);
    chk("R6 tx needs both", 32'(irq), 32'h0);
    wr(8'h20, 32'h00002040);
    repeat (2) @(negedge clk);
    chk("R6 tx irq", 32'(irq), 32'h1);
    wr(8'h20, 32'h00000200);
    repeat (2) @(negedge clk);
    chk("R6 rx idle", 32'(irq), 32'h0);
    push(8'h44, 1'b0);
    repeat (2) @(negedge clk);
    chk("R6 rx irq", 32'(irq), 32'h1);
    rd_chk("R6 drain", 8'h00, 32'h8044);
    repeat (2) @(negedge clk);
    chk("R6 rx clear", 32'(irq), 32'h0);
  endtask

  task automatic t_store;
    wr(8'h22, 32'h1234ABCD);
    rd_chk("R9 ctl3 16b", 8'h22, 32'h0000ABCD);
    wr(8'h24, 32'h00000009);
    rd_chk("R9 fctl", 8'h24, 32'h0009);
    wr(8'h2C, 32'h0000BEEF);
    rd_chk("R9 msec", 8'h2C, 32'hBEEF);
    wr(8'h29, 32'hFFFF0042);
    rd_chk("R9 binc alias", 8'h2B, 32'h0042);
    rd_chk("R9 binc reads 0", 8'h29, 32'h0000);
    wr(8'h2A, 32'h00000077);
    rd_chk("R9 bmod", 8'h2A, 32'h0077);
    wr(8'h23, 32'h00005555);
    rd_chk("R9 ctl4", 8'h23, 32'h0000);
    wr(8'h2D, 32'h00000000);
    rd_chk("R9 test ro", 8'h2D, 32'h0060);
    wr(8'h3F, 32'h0000FFFF);
    rd_chk("R9 unknown", 8'h3F, 32'h0000);
  endtask

  task automatic t_soft;
    push(8'h66, 1'b0);
    repeat (2) @(negedge clk);
    chk("R6 before srst", 32'(irq), 32'h1);
    wr(8'h21, 32'h00000006);
    chk("R8 rx_ready", 32'(rx_ready), 32'h1);
    rd_chk("R8 ctl2 forced", 8'h21, 32'h0007);
    rd_chk("R8 ctl1", 8'h20, 32'h0000);
    rd_chk("R8 ctl3", 8'h22, 32'h0700);
    rd_chk("R8 bcnt", 8'h2B, 32'h0004);
    rd_chk("R8 bmod", 8'h2A, 32'h0000);
    rd_chk("R8 rxd", 8'h00, 32'h4000);
    rd_chk("R8 sts1", 8'h25, 32'h6040);
    rd_chk("R8 fctl kept", 8'h24, 32'h0009);
    rd_chk("R8 msec kept", 8'h2C, 32'hBEEF);
    chk("R8 irq", 32'(irq), 32'h0);
  endtask

  initial begin
    rst_n = 1'b0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    tx_ready = 1'b0; rx_valid = 1'b0; rx_data = '0; rx_brk = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_rx();
    t_backpressure();
    t_break();
    t_w1c();
    t_timing();
    t_tx();
    t_irq();
    t_store();
    t_soft();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule